// File: doc/BRIEF.md
# SATA Host Adapter Register File

This block is the software-visible register file of a SATA host bus adapter that follows the AHCI register model. It decodes 32-bit, word-aligned reads and writes on a simple strobe bus. The address space has two parts. The first is a global host region at the bottom of the map. The second is a row of per-port windows of 128 bytes each, starting at `PORT_BASE`, with one window for each implemented port.

Every register carries its own access rule:

- read-only registers ignore writes;
- plain registers store what is written, sometimes through a bit mask;
- status registers are cleared by writing ones;
- the activity and issue bitmaps can only be set, never cleared, by the bus.

Hardware events enter through per-port set vectors. The masked per-port interrupt status feeds a sticky host interrupt summary, and that summary drives a single interrupt line.

The block also emits three one-cycle strobes:

- a controller-reset strobe;
- a per-port reset strobe, raised when a port's device-detection control field is written from 1 to 0;
- a per-port "check for work" strobe for the command engine, raised by writes to the command or command-issue registers.

Top module: `sata_hba_regfile`

## Requirements
- R1: After reset the host words read as follows. Capabilities (offset 0x00) is 0x4000_0000 ORed with NPORTS-1. Control (0x04) is 0x8000_0000. Interrupt summary (0x08) is 0. Port map (0x0C) is (1<<NPORTS)-1. Version (0x10) is 0x0001_0300. Every port register reads 0, except task-file (port offset 0x20), which reads 0x7F, and signature (0x24), which reads 0xFFFF_FFFF. `irq_o` is low.
- R2: Read data appears on `bus_rdata` in the cycle after `bus_rd`. Host offsets 0x14 to 0x2C, the gap up to `PORT_BASE`, and addresses past the last port window read as 0, and writes to them change nothing.
- R3: A write to host control (0x04) with bit 0 clear stores bits 1:0 with bit 31 forced to 1. A write with bit 0 set returns every register to its R1 value and pulses `hba_reset_o` for one cycle.
- R4: In the host interrupt summary (0x08), bit i is set in every cycle in which port i's status ANDed with its enable is non-zero. Writing a 1 clears a bit, but a bit that is still being set in the same cycle stays 1.
- R5: Port interrupt status (port offset 0x10) is set by `evt_set_i`. Writing a 1 clears a bit, and a hardware set in the same cycle wins over the clear.
- R6: Port interrupt enable (0x14) stores the written value ANDed with 0xFDC0_00FF.
- R7: `irq_o` is high exactly when control bit 1 is set and the summary is non-zero. It rises two clock edges after the event that makes a masked status bit non-zero.
- R8: Writes to capabilities, port map, version, task-file, signature and SATA status (port offset 0x28) have no effect.
- R9: When SATA control (0x2C) holds 1 in bits 3:0 and a write brings 0 in bits 3:0, the port resets. Its status, error, active, issue and command registers clear, `port_reset_o[i]` pulses, and then the new value is stored. Other transitions only store the value.
- R10: SATA error (0x30) is set by `err_set_i` and cleared by writing ones; a hardware set wins over the clear.
- R11: SATA active (0x34) and command issue (0x38) are set-only: the written value is ORed into the contents.
- R12: A write to command (0x18) stores bits 4:0. Any write to command or command issue pulses `engine_check_o[i]` in the following cycle only.
- R13: The four address words at port offsets 0x00 to 0x0C store and return all 32 bits, independently per port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_set_i | input | NPORTS*32 | Per-port interrupt status set bits, port i at [32i+31:32i] |
| err_set_i | input | NPORTS*32 | Per-port SATA error set bits |
| irq_o | output | 1 | Interrupt line |
| hba_reset_o | output | 1 | Controller reset strobe |
| port_reset_o | output | NPORTS | Per-port reset strobe |
| engine_check_o | output | NPORTS | Per-port command engine check strobe |

## Verification
Writes update registers at the edge that samples the strobe. Read data is registered, so a read result is due one edge after `bus_rd`. The strobes are registered at the write edge and are checked at the next falling edge, then checked again one cycle later to confirm they have dropped. The interrupt line passes through two register stages, port status and then the host summary, so the bench checks that it is still low one cycle after an event and high the cycle after that. Every bus operation is driven and sampled on falling edges, which puts each check exactly that number of edges after its stimulus.

// File: rtl/sata_hba_pkg.sv
// Shared constants for the SATA host adapter register file.
// Word indices are the byte offset divided by four.
package sata_hba_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        REGION_NONE = 2'd0,
        REGION_HOST = 2'd1,
        REGION_PORT = 2'd2
    } region_e;

    // host region word indices
    localparam logic [4:0] HW_CAPS    = 5'd0;
    localparam logic [4:0] HW_CTRL    = 5'd1;
    localparam logic [4:0] HW_ISR     = 5'd2;
    localparam logic [4:0] HW_PMAP    = 5'd3;
    localparam logic [4:0] HW_VERSION = 5'd4;
    localparam int         HOST_WORDS = 11;

    // per-port window word indices
    localparam logic [4:0] PW_CLB   = 5'd0;
    localparam logic [4:0] PW_CLBU  = 5'd1;
    localparam logic [4:0] PW_FB    = 5'd2;
    localparam logic [4:0] PW_FBU   = 5'd3;
    localparam logic [4:0] PW_IS    = 5'd4;
    localparam logic [4:0] PW_IE    = 5'd5;
    localparam logic [4:0] PW_CMD   = 5'd6;
    localparam logic [4:0] PW_TFD   = 5'd8;
    localparam logic [4:0] PW_SIG   = 5'd9;
    localparam logic [4:0] PW_SSTS  = 5'd10;
    localparam logic [4:0] PW_SCTL  = 5'd11;
    localparam logic [4:0] PW_SERR  = 5'd12;
    localparam logic [4:0] PW_SACT  = 5'd13;
    localparam logic [4:0] PW_CI    = 5'd14;

    localparam int         WIN_SHIFT = 7;

    localparam logic [31:0] IE_WMASK   = 32'hFDC0_00FF;
    localparam logic [31:0] CMD_WMASK  = 32'h0000_001F;
    localparam logic [31:0] CTRL_WMASK = 32'h0000_0003;
    localparam logic [31:0] CTRL_AE    = 32'h8000_0000;
    localparam logic [31:0] CAPS_BASE  = 32'h4000_0000;
    localparam logic [31:0] VERSION    = 32'h0001_0300;
    localparam logic [31:0] TFD_IDLE   = 32'h0000_007F;
    localparam logic [31:0] SIG_IDLE   = 32'hFFFF_FFFF;

endpackage

// File: rtl/sata_hba_decode.sv
// Address decoder: classifies a byte address as host region, port window
// or unmapped, and extracts the port index and word index.
// Assumes PORT_BASE is a multiple of 128 and lies above the host region.
module sata_hba_decode
    import sata_hba_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NPORTS    = 4,
    parameter int PORT_BASE = 256,
    parameter int PIDX_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [PIDX_W-1:0] port_idx,
    output logic [4:0]        word
);
    localparam logic [ADDR_W-1:0] HOST_END_A  = ADDR_W'(HOST_WORDS * 4);
    localparam logic [ADDR_W-1:0] PORT_BASE_A = ADDR_W'(PORT_BASE);
    localparam logic [ADDR_W-1:0] PORT_END_A  = ADDR_W'(PORT_BASE + NPORTS * 128);

    logic [ADDR_W-1:0] rel;

    // classify address and split it into window index and word
    always_comb begin
        rel      = addr - PORT_BASE_A;
        port_idx = PIDX_W'(rel >> WIN_SHIFT);
        word     = addr[6:2];
        if (addr < HOST_END_A)
            region = REGION_HOST;
        else if (addr >= PORT_BASE_A && addr < PORT_END_A)
            region = REGION_PORT;
        else
            region = REGION_NONE;
    end
endmodule

// File: rtl/sata_hba_host.sv
// Global host registers: control, sticky interrupt summary and the
// constant identification words. Produces the interrupt line and the
// controller reset request (combinational, consumed at the same edge).
module sata_hba_host
    import sata_hba_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [4:0]        word,
    input  logic [31:0]       wdata,
    input  logic [NPORTS-1:0] pending,
    output logic [31:0]       rdata,
    output logic              irq,
    output logic              reset_req
);
    localparam logic [31:0] CAPS_VAL = CAPS_BASE | 32'(NPORTS - 1);
    localparam logic [31:0] PMAP_VAL = 32'((64'd1 << NPORTS) - 64'd1);

    logic [31:0]       ctrl_q;
    logic [NPORTS-1:0] isr_q;
    logic              wr_ctrl, wr_isr;
    logic [NPORTS-1:0] isr_clr;

    // write strobes per host word
    always_comb begin
        wr_ctrl   = wr_sel && word == HW_CTRL;
        wr_isr    = wr_sel && word == HW_ISR;
        reset_req = wr_ctrl && wdata[0];
        isr_clr   = wr_isr ? wdata[NPORTS-1:0] : '0;
    end

    // control word and interrupt summary state
    always_ff @(posedge clk) begin
        if (!rst_n || reset_req) begin
            ctrl_q <= CTRL_AE;
            isr_q  <= '0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= (wdata & CTRL_WMASK) | CTRL_AE;
            isr_q <= (isr_q & ~isr_clr) | pending;
        end
    end

    // interrupt line
    always_comb irq = ctrl_q[1] && (|isr_q);

    // read multiplexer for host words
    always_comb begin
        case (word)
            HW_CAPS:    rdata = CAPS_VAL;
            HW_CTRL:    rdata = ctrl_q;
            HW_ISR:     rdata = 32'(isr_q);
            HW_PMAP:    rdata = PMAP_VAL;
            HW_VERSION: rdata = VERSION;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/sata_hba_port.sv
// One port register window. Applies per-word write rules, merges
// hardware set vectors, detects the detection-field 1->0 reset and
// produces registered reset and engine-check strobes.
module sata_hba_port
    import sata_hba_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hba_reset,
    input  logic        wr_sel,
    input  logic [4:0]  word,
    input  logic [31:0] wdata,
    input  logic [31:0] evt_set,
    input  logic [31:0] err_set,
    output logic [31:0] rdata,
    output logic        pending,
    output logic        port_reset_pulse,
    output logic        engine_check_pulse
);
    logic [31:0] clb_q, clbu_q, fb_q, fbu_q;
    logic [31:0] is_q, ie_q, cmd_q, sctl_q, serr_q, sact_q, ci_q;
    logic wr_clb, wr_clbu, wr_fb, wr_fbu, wr_is, wr_ie, wr_cmd;
    logic wr_sctl, wr_serr, wr_sact, wr_ci, det_drop;
    logic [31:0] is_clr, serr_clr;

    // per-word write strobes and the detection-drop condition
    always_comb begin
        wr_clb   = wr_sel && word == PW_CLB;
        wr_clbu  = wr_sel && word == PW_CLBU;
        wr_fb    = wr_sel && word == PW_FB;
        wr_fbu   = wr_sel && word == PW_FBU;
        wr_is    = wr_sel && word == PW_IS;
        wr_ie    = wr_sel && word == PW_IE;
        wr_cmd   = wr_sel && word == PW_CMD;
        wr_sctl  = wr_sel && word == PW_SCTL;
        wr_serr  = wr_sel && word == PW_SERR;
        wr_sact  = wr_sel && word == PW_SACT;
        wr_ci    = wr_sel && word == PW_CI;
        det_drop = wr_sctl && sctl_q[3:0] == 4'd1 && wdata[3:0] == 4'd0;
        is_clr   = wr_is   ? wdata : '0;
        serr_clr = wr_serr ? wdata : '0;
    end

    // address words, stored verbatim
    always_ff @(posedge clk) begin
        if (!rst_n || hba_reset) begin
            clb_q  <= '0;
            clbu_q <= '0;
            fb_q   <= '0;
            fbu_q  <= '0;
        end else begin
            if (wr_clb)  clb_q  <= wdata;
            if (wr_clbu) clbu_q <= wdata;
            if (wr_fb)   fb_q   <= wdata;
            if (wr_fbu)  fbu_q  <= wdata;
        end
    end

    // status, control and bitmap words with their access rules
    always_ff @(posedge clk) begin
        if (!rst_n || hba_reset) begin
            is_q   <= '0;
            ie_q   <= '0;
            cmd_q  <= '0;
            sctl_q <= '0;
            serr_q <= '0;
            sact_q <= '0;
            ci_q   <= '0;
        end else begin
            if (wr_ie)   ie_q   <= wdata & IE_WMASK;
            if (wr_sctl) sctl_q <= wdata;
            if (det_drop) begin
                is_q   <= evt_set;
                serr_q <= err_set;
                cmd_q  <= '0;
                sact_q <= '0;
                ci_q   <= '0;
            end else begin
                is_q   <= (is_q & ~is_clr) | evt_set;
                serr_q <= (serr_q & ~serr_clr) | err_set;
                if (wr_cmd)  cmd_q  <= wdata & CMD_WMASK;
                if (wr_sact) sact_q <= sact_q | wdata;
                if (wr_ci)   ci_q   <= ci_q | wdata;
            end
        end
    end

    // one-cycle strobes following the triggering write
    always_ff @(posedge clk) begin
        if (!rst_n || hba_reset) begin
            port_reset_pulse   <= 1'b0;
            engine_check_pulse <= 1'b0;
        end else begin
            port_reset_pulse   <= det_drop;
            engine_check_pulse <= wr_cmd || wr_ci;
        end
    end

    // masked status request toward the host summary
    always_comb pending = |(is_q & ie_q);

    // read multiplexer for the window
    always_comb begin
        case (word)
            PW_CLB:  rdata = clb_q;
            PW_CLBU: rdata = clbu_q;
            PW_FB:   rdata = fb_q;
            PW_FBU:  rdata = fbu_q;
            PW_IS:   rdata = is_q;
            PW_IE:   rdata = ie_q;
            PW_CMD:  rdata = cmd_q;
            PW_TFD:  rdata = TFD_IDLE;
            PW_SIG:  rdata = SIG_IDLE;
            PW_SSTS: rdata = '0;
            PW_SCTL: rdata = sctl_q;
            PW_SERR: rdata = serr_q;
            PW_SACT: rdata = sact_q;
            PW_CI:   rdata = ci_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/sata_hba_regfile.sv
// Top of the SATA host adapter register file. Decodes the bus, fans
// writes out to the host block and one window per port, registers read
// data and the controller reset strobe.
// Assumes one access per cycle and word-aligned addresses; NPORTS <= 32.
module sata_hba_regfile
    import sata_hba_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NPORTS    = 4,
    parameter int PORT_BASE = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NPORTS*32-1:0]   evt_set_i,
    input  logic [NPORTS*32-1:0]   err_set_i,
    output logic                   irq_o,
    output logic                   hba_reset_o,
    output logic [NPORTS-1:0]      port_reset_o,
    output logic [NPORTS-1:0]      engine_check_o
);
    localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    region_e           region;
    logic [PIDX_W-1:0] port_idx;
    logic [4:0]        word;
    logic [31:0]       host_rdata;
    logic [31:0]       port_rdata [NPORTS];
    logic [NPORTS-1:0] pending;
    logic              reset_req;
    logic [31:0]       rd_next;

    sata_hba_decode #(
        .ADDR_W(ADDR_W), .NPORTS(NPORTS), .PORT_BASE(PORT_BASE), .PIDX_W(PIDX_W)
    ) u_decode (
        .addr(bus_addr), .region(region), .port_idx(port_idx), .word(word)
    );

    sata_hba_host #(.NPORTS(NPORTS)) u_host (
        .clk(clk), .rst_n(rst_n),
        .wr_sel(bus_wr && region == REGION_HOST),
        .word(word), .wdata(bus_wdata), .pending(pending),
        .rdata(host_rdata), .irq(irq_o), .reset_req(reset_req)
    );

    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_port
        sata_hba_port u_port (
            .clk(clk), .rst_n(rst_n), .hba_reset(reset_req),
            .wr_sel(bus_wr && region == REGION_PORT && port_idx == PIDX_W'(gi)),
            .word(word), .wdata(bus_wdata),
            .evt_set(evt_set_i[gi*32 +: 32]),
            .err_set(err_set_i[gi*32 +: 32]),
            .rdata(port_rdata[gi]), .pending(pending[gi]),
            .port_reset_pulse(port_reset_o[gi]),
            .engine_check_pulse(engine_check_o[gi])
        );
    end

    // select read source by region and window
    always_comb begin
        rd_next = '0;
        if (region == REGION_HOST)
            rd_next = host_rdata;
        else if (region == REGION_PORT)
            for (int i = 0; i < NPORTS; i++)
                if (port_idx == PIDX_W'(i))
                    rd_next = port_rdata[i];
    end

    // registered read data and controller reset strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata   <= '0;
            hba_reset_o <= 1'b0;
        end else begin
            if (bus_rd)
                bus_rdata <= rd_next;
            hba_reset_o <= reset_req;
        end
    end
endmodule

// File: rtl/sata_hba_regfile_chk.sv
// Checker for sata_hba_regfile, observing only its ports; bound below.
module sata_hba_regfile_chk #(
    parameter int ADDR_W    = 12,
    parameter int NPORTS    = 4,
    parameter int PORT_BASE = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              irq_o,
    input logic              hba_reset_o,
    input logic [NPORTS-1:0] port_reset_o,
    input logic [NPORTS-1:0] engine_check_o
);
    logic [NPORTS-1:0] kick_vec;
    logic              void_addr;

    // expected engine-check targets and unmapped-address flag
    always_comb begin
        for (int i = 0; i < NPORTS; i++)
            kick_vec[i] = bus_wr
                && (bus_addr >> 7) == ADDR_W'(PORT_BASE / 128 + i)
                && (bus_addr[6:2] == 5'd6 || bus_addr[6:2] == 5'd14);
        void_addr = bus_addr >= ADDR_W'(44)
                 && (bus_addr < ADDR_W'(PORT_BASE)
                     || bus_addr >= ADDR_W'(PORT_BASE + NPORTS * 128));
    end

    AST_ENGINE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> engine_check_o == $past(kick_vec)); // R12
    AST_PORT_RESET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_reset_o)); // R9
    AST_PORT_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_reset_o) |-> $past(bus_wr)); // R9
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hba_reset_o |-> (!irq_o && port_reset_o == '0 && engine_check_o == '0)); // R3
    AST_VOID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && void_addr) |=> bus_rdata == 32'd0); // R2
endmodule

bind sata_hba_regfile sata_hba_regfile_chk #(
    .ADDR_W(ADDR_W), .NPORTS(NPORTS), .PORT_BASE(PORT_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .hba_reset_o(hba_reset_o), .port_reset_o(port_reset_o),
    .engine_check_o(engine_check_o)
);

// File: tb/sata_hba_regfile_test.sv
// Directed bench for sata_hba_regfile: one task per scenario.
module sata_hba_regfile_test;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP*32-1:0] evt_set = '0, err_set = '0;
    logic          irq_o, hba_reset_o;
    logic [NP-1:0] port_reset_o, engine_check_o;

    int n_chk = 0, n_bad = 0;
    logic [NP-1:0] snap_eng, snap_prst;
    logic          snap_hrst;

    always #5 clk = ~clk;

    sata_hba_regfile uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_set_i(evt_set), .err_set_i(err_set), .irq_o(irq_o),
        .hba_reset_o(hba_reset_o), .port_reset_o(port_reset_o),
        .engine_check_o(engine_check_o)
    );

    function automatic logic [11:0] pa(int p, int off);
        return 12'(256 + p * 128 + off);
    endfunction

    task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        snap_eng = engine_check_o; snap_prst = port_reset_o; snap_hrst = hba_reset_o;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(string what, logic [11:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(what, d, exp);
    endtask

    task automatic pulse_evt(int p, logic [31:0] bits);
        @(negedge clk);
        evt_set[p*32 +: 32] = bits;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic t_reset;
        chk("R1 irq after reset", 32'(irq_o), 0);
        rd_chk("R1 caps", 12'h000, 32'h4000_0003);
        rd_chk("R1 control", 12'h004, 32'h8000_0000);
        rd_chk("R1 summary", 12'h008, 0);
        rd_chk("R1 port map", 12'h00C, 32'hF);
        rd_chk("R1 version", 12'h010, 32'h0001_0300);
        rd_chk("R1 task-file", pa(1, 'h20), 32'h7F);
        rd_chk("R1 signature", pa(1, 'h24), 32'hFFFF_FFFF);
        rd_chk("R1 port status", pa(0, 'h10), 0);
    endtask

    task automatic t_readonly;
        wr(12'h000, 32'h0); wr(12'h00C, 32'h0); wr(12'h010, 32'hDEAD);
        rd_chk("R8 caps after write", 12'h000, 32'h4000_0003);
        rd_chk("R8 port map after write", 12'h00C, 32'hF);
        rd_chk("R8 version after write", 12'h010, 32'h0001_0300);
        wr(pa(2, 'h20), 0); wr(pa(2, 'h24), 0); wr(pa(2, 'h28), 32'h123);
        rd_chk("R8 task-file after write", pa(2, 'h20), 32'h7F);
        rd_chk("R8 signature after write", pa(2, 'h24), 32'hFFFF_FFFF);
        rd_chk("R8 sata status after write", pa(2, 'h28), 0);
    endtask

    task automatic t_unmapped;
        wr(12'h014, 32'hFFFF_FFFF);
        rd_chk("R2 unimplemented host word", 12'h014, 0);
        rd_chk("R2 host gap", 12'h080, 0);
        wr(12'h300 + 12'h38, 32'hFFFF_FFFF);
        rd_chk("R2 beyond last port", 12'h338, 0);
        rd_chk("R2 last port issue untouched", pa(3, 'h38), 0);
    endtask

    task automatic t_addr_words;
        wr(pa(1, 'h00), 32'h1234_5678);
        wr(pa(1, 'h0C), 32'h9ABC_DEF0);
        rd_chk("R13 list base", pa(1, 'h00), 32'h1234_5678);
        rd_chk("R13 receive base high", pa(1, 'h0C), 32'h9ABC_DEF0);
        rd_chk("R13 other port untouched", pa(0, 'h00), 0);
    endtask

    task automatic t_enable_mask;
        wr(pa(3, 'h14), 32'hFFFF_FFFF);
        rd_chk("R6 enable mask", pa(3, 'h14), 32'hFDC0_00FF);
    endtask

    task automatic t_set_only;
        wr(pa(2, 'h34), 32'h5); wr(pa(2, 'h34), 32'hA); wr(pa(2, 'h34), 32'h0);
        rd_chk("R11 active ORs", pa(2, 'h34), 32'hF);
        wr(pa(2, 'h38), 32'h1);
        chk("R12 issue strobe", 32'(snap_eng), 32'h4);
        @(negedge clk);
        chk("R12 issue strobe drops", 32'(engine_check_o), 0);
        wr(pa(2, 'h38), 32'h4);
        rd_chk("R11 issue ORs", pa(2, 'h38), 32'h5);
    endtask

    task automatic t_command;
        wr(pa(3, 'h18), 32'hFFFF_FFFF);
        chk("R12 command strobe", 32'(snap_eng), 32'h8);
        rd_chk("R12 command stores low bits", pa(3, 'h18), 32'h1F);
        wr(pa(3, 'h00), 32'h1);
        chk("R12 no strobe for other word", 32'(snap_eng), 0);
    endtask

    task automatic t_port_status;
        pulse_evt(1, 32'h21);
        rd_chk("R5 status set by event", pa(1, 'h10), 32'h21);
        wr(pa(1, 'h10), 32'h1);
        rd_chk("R5 write-one clears", pa(1, 'h10), 32'h20);
        @(negedge clk);
        evt_set[32 +: 32] = 32'h2; bus_wr = 1'b1; bus_addr = pa(1, 'h10); bus_wdata = 32'h2;
        @(negedge clk);
        evt_set = '0; bus_wr = 1'b0;
        rd_chk("R5 set wins over clear", pa(1, 'h10), 32'h22);
    endtask

    task automatic t_irq;
        wr(pa(0, 'h14), 32'h1);
        wr(12'h004, 32'h2);
        rd_chk("R3 control stores enable", 12'h004, 32'h8000_0002);
        pulse_evt(0, 32'h1);
        chk("R7 irq not yet", 32'(irq_o), 0);
        @(negedge clk);
        chk("R7 irq two edges after event", 32'(irq_o), 1);
        rd_chk("R4 summary bit set", 12'h008, 32'h1);
        wr(12'h008, 32'h1);
        rd_chk("R4 summary held while pending", 12'h008, 32'h1);
        wr(pa(0, 'h10), 32'h1);
        rd_chk("R4 summary sticky", 12'h008, 32'h1);
        wr(12'h008, 32'h1);
        rd_chk("R4 summary cleared", 12'h008, 0);
        chk("R7 irq low after clear", 32'(irq_o), 0);
        pulse_evt(0, 32'h1);
        @(negedge clk);
        wr(12'h004, 32'h0);
        chk("R7 irq gated by enable", 32'(irq_o), 0);
        wr(pa(0, 'h10), 32'h1); wr(12'h008, 32'hF);
    endtask

    task automatic t_error;
        @(negedge clk);
        err_set[64 +: 32] = 32'h300;
        @(negedge clk);
        err_set = '0;
        rd_chk("R10 error set", pa(2, 'h30), 32'h300);
        wr(pa(2, 'h30), 32'h100);
        rd_chk("R10 error write-one clears", pa(2, 'h30), 32'h200);
    endtask

    task automatic t_detect_reset;
        wr(pa(2, 'h2C), 32'h1);
        wr(pa(2, 'h2C), 32'h4);
        chk("R9 no reset on 1 to 4", 32'(snap_prst), 0);
        rd_chk("R9 active kept", pa(2, 'h34), 32'hF);
        wr(pa(2, 'h2C), 32'h301);
        wr(pa(2, 'h2C), 32'h300);
        chk("R9 reset strobe", 32'(snap_prst), 32'h4);
        @(negedge clk);
        chk("R9 reset strobe drops", 32'(port_reset_o), 0);
        rd_chk("R9 active cleared", pa(2, 'h34), 0);
        rd_chk("R9 issue cleared", pa(2, 'h38), 0);
        rd_chk("R9 error cleared", pa(2, 'h30), 0);
        rd_chk("R9 new control stored", pa(2, 'h2C), 32'h300);
    endtask

    task automatic t_ctrl_reset;
        wr(pa(1, 'h00), 32'hCAFE_0000);
        wr(12'h004, 32'h2);
        wr(12'h004, 32'h1);
        chk("R3 controller reset strobe", 32'(snap_hrst), 1);
        @(negedge clk);
        chk("R3 reset strobe drops", 32'(hba_reset_o), 0);
        rd_chk("R3 control back to default", 12'h004, 32'h8000_0000);
        rd_chk("R3 port word back to default", pa(1, 'h00), 0);
        rd_chk("R3 port map unchanged", 12'h00C, 32'hF);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1..R13 actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readonly();
        t_unmapped();
        t_addr_words();
        t_enable_mask();
        t_set_only();
        t_command();
        t_port_status();
        t_irq();
        t_error();
        t_detect_reset();
        t_ctrl_reset();
        summary();
    end
endmodule